// File: doc/BRIEF.md
# Prescaled Reload Counter Pair

This block divides a prescale tick enable down into slower events. A down-counter steps toward zero on every tick. On the tick that finds it already at zero, it reloads from a programmable divide value, and a 32-bit event counter advances by one on that same tick. The event counter therefore advances once every divide+1 ticks. The divide value, the live down-count and the event count are all exposed as read values. Software can overwrite any of them through per-register write strobes that share one data bus. The register block that owns the bus decode drives these strobes, and a separate clock-enable source supplies the tick.

The down-counter is classified each cycle into one of three named phases. PH_RUN means the count is non-zero. PH_EXPIRE means the count is zero and the divide value is non-zero. PH_HOLD means the count is zero and the divide value is zero. The phases change as follows on a tick:

- In PH_RUN the count decrements. It leaves to PH_EXPIRE or PH_HOLD when it reaches zero.
- In PH_EXPIRE the count reloads, which returns the block to PH_RUN, and the event counter is stepped.
- In PH_HOLD the count stays at zero, the block stays in PH_HOLD, and the event counter is stepped on every tick.

A software write can move the block between any two phases.

Top module: `prescale_pair`

## Requirements
- R1: After reset the divide value, the down-count and the event count all read zero.
- R2: On a tick with a non-zero down-count, the down-count decreases by exactly one and the event count is unchanged. With no tick and no write, all three values hold.
- R3: On a tick with a down-count of zero, the down-count loads the divide value and the event count increases by one. Both changes appear at the same clock edge.
- R4: With a divide value of 5 and a starting down-count of 7, successive ticks give the down-count 7,6,5,4,3,2,1,0,5,4,3,2,1,0,5. The event count steps on the 8th and the 14th tick.
- R5: With a divide value of zero, the down-count stays at zero once it gets there, and the event count increases on every tick after that.
- R6: A starting down-count above the divide value counts down normally. Every later period then lasts divide+1 ticks.
- R7: A write to the down-count in the same cycle as a tick wins over the tick for the down-count. The event count still follows the tick as judged by the old down-count.
- R8: A write to the event count in the same cycle as a tick wins over any increment from that tick.
- R9: A write to the divide value does not change a down-count already in progress. The new value is used at the next reload.
- R10: The event count wraps from 0xFFFFFFFF to zero on an increment, and no flag is raised.
- R11: The read values reflect the registers directly and change at the clock edge that updates them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescale tick enable, one cycle per count step |
| div_we | input | 1 | Write strobe for the divide value |
| down_we | input | 1 | Write strobe for the down-count |
| evt_we | input | 1 | Write strobe for the event count |
| wdata | input | 32 | Shared write data |
| div_rd | output | 32 | Current divide value |
| down_rd | output | 32 | Current down-count |
| evt_rd | output | 32 | Current event count |

## Verification
The hardest situations to reach from the ports are the ones where a tick and a write arrive in the same cycle while the down-count is exactly zero. In those cycles the priority of the write and the reload or increment all act at once. The bench uses the write strobes to place the down-count at zero, then raises a strobe together with the tick. The near-overflow event count is reached the same way, by writing 0xFFFFFFFF into the event count rather than counting up to it. The long-run behaviour is covered by a sweep over small divide values and starting counts, and each tick in the sweep is compared against a closed-form division formula.

// File: rtl/prescale_pkg.sv
package prescale_pkg;
    typedef enum logic [1:0] {
        PH_RUN    = 2'd0,
        PH_EXPIRE = 2'd1,
        PH_HOLD   = 2'd2
    } phase_e;
endpackage

// File: rtl/prescale_down.sv
module prescale_down
    import prescale_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         div_we,
    input  logic         load_we,
    input  logic [W-1:0] div_d,
    input  logic [W-1:0] load_d,
    output logic [W-1:0] div_q,
    output logic [W-1:0] down_q,
    output logic         wrap_o
);
    localparam logic [W-1:0] ONE = W'(1);

    phase_e       phase;
    logic [W-1:0] down_nx;

    // Phase classification of the current count
    always_comb begin
        if (down_q != '0)      phase = PH_RUN;
        else if (div_q == '0)  phase = PH_HOLD;
        else                   phase = PH_EXPIRE;
    end

    // Next count and wrap pulse
    always_comb begin
        down_nx = down_q;
        wrap_o  = 1'b0;
        if (tick) begin
            unique case (phase)
                PH_RUN:    down_nx = down_q - ONE;
                PH_EXPIRE: begin down_nx = div_q; wrap_o = 1'b1; end
                PH_HOLD:   begin down_nx = '0;    wrap_o = 1'b1; end
                default:   down_nx = down_q;
            endcase
        end
        if (load_we) down_nx = load_d;
    end

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            down_q <= '0;
            div_q  <= '0;
        end else begin
            down_q <= down_nx;
            if (div_we) div_q <= div_d;
        end
    end

    p_decrement_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_we && down_q != '0) |=> (down_q == $past(down_q) - ONE));
    p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_we) |=> $stable(down_q));
    p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_we && down_q == '0) |=> (down_q == $past(div_q)));
    p_load_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_we |=> (down_q == $past(load_d)));
    p_div_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        div_we |=> (div_q == $past(div_d)));
endmodule

// File: rtl/prescale_event.sv
module prescale_event #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cnt_q
);
    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n)   cnt_q <= '0;
        else if (we)  cnt_q <= wdata;
        else if (inc) cnt_q <= cnt_q + ONE;
    end

    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !we) |=> (cnt_q == $past(cnt_q) + ONE));
    p_count_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (cnt_q == $past(wdata)));
    p_count_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !we) |=> $stable(cnt_q));
endmodule

// File: rtl/prescale_pair.sv
module prescale_pair #(
    parameter int DIV_W = 32,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             div_we,
    input  logic             down_we,
    input  logic             evt_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DIV_W-1:0] div_rd,
    output logic [DIV_W-1:0] down_rd,
    output logic [CNT_W-1:0] evt_rd
);
    localparam int DATA_W = (DIV_W > CNT_W) ? DIV_W : CNT_W;

    logic wrap;

    prescale_down #(.W(DIV_W)) u_down (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .div_we  (div_we),
        .load_we (down_we),
        .div_d   (wdata[DIV_W-1:0]),
        .load_d  (wdata[DIV_W-1:0]),
        .div_q   (div_rd),
        .down_q  (down_rd),
        .wrap_o  (wrap)
    );

    prescale_event #(.W(CNT_W)) u_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (wrap),
        .we    (evt_we),
        .wdata (wdata[CNT_W-1:0]),
        .cnt_q (evt_rd)
    );

    p_step_needs_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !evt_we) |=> $stable(evt_rd));
endmodule

// File: tb/prescale_pair_test.sv
`timescale 1ns/1ps
module prescale_pair_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        div_we = 1'b0;
    logic        down_we = 1'b0;
    logic        evt_we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] div_rd, down_rd, evt_rd;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    prescale_pair uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .div_we(div_we),
        .down_we(down_we), .evt_we(evt_we), .wdata(wdata),
        .div_rd(div_rd), .down_rd(down_rd), .evt_rd(evt_rd)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle with the given strobes, inputs driven at the falling edge
    task automatic cyc(input bit t, input bit dw, input bit lw, input bit ew, input logic [31:0] d);
        @(negedge clk);
        tick = t; div_we = dw; down_we = lw; evt_we = ew; wdata = d;
        @(negedge clk);
        tick = 0; div_we = 0; down_we = 0; evt_we = 0;
    endtask

    task automatic setup(input logic [31:0] dv, input logic [31:0] st, input logic [31:0] ev);
        cyc(0, 1, 0, 0, dv);
        cyc(0, 0, 1, 0, st);
        cyc(0, 0, 0, 1, ev);
    endtask

    // Closed-form expectation after n ticks from start st, divide dv, count 0
    function automatic longint exp_down(longint dv, longint st, longint n);
        longint y;
        if (n < st) return st - n;
        if (dv == 0) return 0;
        y = n - st + dv;
        return dv - (y % (dv + 1));
    endfunction

    function automatic longint exp_evt(longint dv, longint st, longint n);
        longint y;
        if (n < st) return 0;
        if (dv == 0) return n - st;
        y = n - st + dv;
        return y / (dv + 1);
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int seq_r4[15];
        seq_r4 = '{7,6,5,4,3,2,1,0,5,4,3,2,1,0,5};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        chk("R1 div", div_rd, 0);
        chk("R1 down", down_rd, 0);
        chk("R1 evt", evt_rd, 0);

        // R2 hold without tick
        setup(3, 2, 9);
        chk("R11 readback div", div_rd, 3);
        chk("R11 readback down", down_rd, 2);
        chk("R11 readback evt", evt_rd, 9);
        repeat (4) cyc(0, 0, 0, 0, 32'hFFFF);
        chk("R2 hold down", down_rd, 2);
        chk("R2 hold evt", evt_rd, 9);
        cyc(1, 0, 0, 0, 0);
        chk("R2 decrement", down_rd, 1);
        chk("R2 evt unchanged", evt_rd, 9);

        // R4 documented sequence
        setup(5, 7, 0);
        chk("R4 start", down_rd, 7);
        for (int i = 1; i < 15; i++) begin
            cyc(1, 0, 0, 0, 0);
            chk("R4 down", down_rd, seq_r4[i]);
            chk("R4 evt", evt_rd, (i >= 14) ? 2 : (i >= 8) ? 1 : 0);
        end

        // R3 R5 R6 sweep
        for (int dv = 0; dv <= 4; dv++) begin
            for (int st = 0; st <= 6; st++) begin
                setup(dv, st, 0);
                for (int n = 1; n <= 12; n++) begin
                    cyc(1, 0, 0, 0, 0);
                    chk((dv == 0) ? "R5 down" : (st > dv) ? "R6 down" : "R3 down",
                        down_rd, 32'(exp_down(dv, st, n)));
                    chk((dv == 0) ? "R5 evt" : (st > dv) ? "R6 evt" : "R3 evt",
                        evt_rd, 32'(exp_evt(dv, st, n)));
                end
            end
        end

        // R7 down write with tick at zero: write wins, event still steps
        setup(4, 0, 10);
        cyc(1, 0, 1, 0, 2);
        chk("R7 down write wins", down_rd, 2);
        chk("R7 evt steps", evt_rd, 11);
        // R7 down write with tick while running
        cyc(1, 0, 1, 0, 9);
        chk("R7 down write wins run", down_rd, 9);
        chk("R7 evt unchanged run", evt_rd, 11);

        // R8 event write with tick at zero
        setup(4, 0, 10);
        cyc(1, 0, 0, 1, 100);
        chk("R8 evt write wins", evt_rd, 100);
        chk("R8 down reloads", down_rd, 4);

        // R9 divide change mid-count
        setup(2, 3, 0);
        cyc(1, 0, 0, 0, 0);
        cyc(0, 1, 0, 0, 6);
        chk("R9 down untouched", down_rd, 2);
        cyc(1, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0);
        chk("R9 reaches zero", down_rd, 0);
        cyc(1, 0, 0, 0, 0);
        chk("R9 new reload", down_rd, 6);
        chk("R9 evt", evt_rd, 1);
        // divide write on the reload tick uses the old value
        setup(3, 0, 0);
        cyc(1, 1, 0, 0, 8);
        chk("R9 same-cycle old reload", down_rd, 3);
        chk("R9 same-cycle div", div_rd, 8);

        // R10 wrap
        setup(1, 0, 32'hFFFF_FFFF);
        cyc(1, 0, 0, 0, 0);
        chk("R10 wrap", evt_rd, 0);
        chk("R10 reload", down_rd, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule